// File: doc/BRIEF.md
# Interval Timer with Deferred Reload

This block is a 16-bit interval timer for one-shot or periodic use. It counts down from a load value to zero, or up from zero to the load value. Each time it reaches the end of its interval it raises a timeout event. A comparator raises a match event when the count equals a programmed match value. A snapshot register can record, at each periodic timeout, how many cycles the timer has run since it started. The timer can hold its start until a trigger arrives from a neighbouring timer in a chain, and it pulses a chain output at each timeout.

The load value and the match value each have their own write port and their own update-timing select. A write takes effect either on the next clock edge or is held back until the next timeout. Held writes are also applied at the moment the timer is enabled. Timeout and match events each drive an interrupt line and a trigger line for a DMA or ADC consumer. The two event kinds use different masking: disabling the timeout interrupt leaves the timeout trigger running, while clearing the match enable silences both match outputs.

Top module: `tmr_core`

## Requirements
- R1: `mode_i` 1 selects one-shot and 2 selects periodic. Codes 0 and 3 leave the timer idle: it does not count and produces no events. A start happens only on a rising edge of `en_i` while the mode code is 1 or 2, and the mode must be held while enabled.
- R2: Counting down (`dir_up_i`=0), the timer starts at the active load value L and decrements by one per cycle. The cycle in which the count is 0 is a timeout. In periodic mode the next cycle reloads L, so the period is L+1 cycles.
- R3: Counting up (`dir_up_i`=1), the timer starts at 0 and increments by one per cycle. The cycle in which the count equals the active load value is a timeout. In periodic mode the next cycle restarts at 0.
- R4: In one-shot mode, after the first timeout the count holds its final value and no further timeout or match event occurs until `en_i` is dropped and raised again.
- R5: A load write with `load_defer_i`=0 becomes the active load value on the next edge, and a down-counting running timer restarts from it on that same edge, with no timeout in that cycle. With `load_defer_i`=1 while counting down, the value is held pending until the next timeout. Counting up, the defer select is ignored.
- R6: A match write with `match_defer_i`=0 becomes the active match value on the next edge. With `match_defer_i`=1 it is held pending until the next timeout.
- R7: Any pending load or match value is applied on the rising edge of `en_i`, and a down-counting start uses the pending load value.
- R8: With `wait_trig_i`=1, an enabled timer holds its start count and does not count until a cycle in which `chain_trig_i` is 1. It counts from the following cycle.
- R9: A cycle counter restarts at 0 at each start and increments on each running cycle. In periodic mode with `snap_en_i`=1, `snap_o` takes the counter's value at each timeout. A snapshot happens only together with a timeout.
- R10: Each timeout makes `to_trig_o` and `chain_trig_o` 1 for one cycle, one cycle after the terminal count. `to_irq_o` follows them unless `to_irq_dis_i` was 1, and the disable has no effect on the two trigger outputs.
- R11: A running cycle whose count equals the active match value makes `match_irq_o` and `match_trig_o` 1 on the next cycle, but only if `match_irq_en_i` was 1. When it was 0, neither output fires.
- R12: After reset all outputs are 0. Dropping `en_i` stops the timer at once: the count holds and no further events occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Timer enable |
| mode_i | input | 2 | 1 one-shot, 2 periodic, others idle |
| dir_up_i | input | 1 | 1 count up, 0 count down |
| load_defer_i | input | 1 | Hold load writes until timeout |
| match_defer_i | input | 1 | Hold match writes until timeout |
| snap_en_i | input | 1 | Snapshot enable (periodic) |
| wait_trig_i | input | 1 | Wait for chain trigger before counting |
| chain_trig_i | input | 1 | Trigger from previous timer in chain |
| to_irq_dis_i | input | 1 | Timeout interrupt disable |
| match_irq_en_i | input | 1 | Match interrupt and trigger enable |
| load_we_i | input | 1 | Load value write strobe |
| load_val_i | input | 16 | Load value |
| match_we_i | input | 1 | Match value write strobe |
| match_val_i | input | 16 | Match value |
| count_o | output | 16 | Current count |
| snap_o | output | 16 | Snapshot register |
| to_irq_o | output | 1 | Timeout interrupt pulse |
| match_irq_o | output | 1 | Match interrupt pulse |
| to_trig_o | output | 1 | Timeout trigger to DMA/ADC |
| match_trig_o | output | 1 | Match trigger to DMA/ADC |
| chain_trig_o | output | 1 | Chain trigger out |

## Verification
The count is registered, so it moves on the edge after the stimulus that causes the move. A write or a start becomes visible in `count_o` one cycle after the strobe was sampled. Every event output and the snapshot are due one cycle after the cycle in which the count showed the terminal or match value. The bench drives inputs on the falling edge and runs a reference model on the rising edge, then compares every output on the next falling edge, so each result is checked exactly in the cycle it is due.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } tmr_st_e;

  localparam logic [1:0] MODE_ONE = 2'd1;
  localparam logic [1:0] MODE_PER = 2'd2;
endpackage

// File: rtl/tmr_shadow.sv
// Active/pending value pair with immediate or deferred update
module tmr_shadow #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] val_i,
  input  logic         defer_i,
  input  logic         apply_i,
  output logic [W-1:0] act_o,
  output logic [W-1:0] eff_o,
  output logic         imm_o
);
  logic [W-1:0] act_q, pend_q;
  logic         vld_q;

  assign imm_o = we_i & ~defer_i;
  assign eff_o = vld_q ? pend_q : act_q;
  assign act_o = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      pend_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      if (we_i && defer_i) begin
        pend_q <= val_i;
        vld_q  <= 1'b1;
      end else if (apply_i && vld_q) begin
        vld_q <= 1'b0;
      end
      if (imm_o)                act_q <= val_i;
      else if (apply_i && vld_q) act_q <= pend_q;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
// Run control and count datapath
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [1:0]   mode_i,
  input  logic         dir_up_i,
  input  logic         wait_trig_i,
  input  logic         chain_trig_i,
  input  logic [W-1:0] load_act_i,
  input  logic [W-1:0] load_eff_i,
  input  logic         imm_load_i,
  input  logic [W-1:0] imm_val_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] ticks_o,
  output logic         run_o,
  output logic         tc_o,
  output logic         start_o
);
  tmr_st_e      st_q;
  logic [W-1:0] cnt_q, ticks_q;
  logic         en_q;
  logic         mode_ok, terminal, restart, oneshot;

  assign mode_ok  = (mode_i == MODE_ONE) || (mode_i == MODE_PER);
  assign oneshot  = (mode_i == MODE_ONE);
  assign terminal = dir_up_i ? (cnt_q == load_act_i) : (cnt_q == '0);
  assign run_o    = (st_q == ST_RUN) && en_i;
  assign restart  = imm_load_i && !dir_up_i;
  assign tc_o     = run_o && terminal && !restart;
  assign start_o  = en_i && !en_q;
  assign cnt_o    = cnt_q;
  assign ticks_o  = ticks_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      ticks_q <= '0;
      en_q    <= 1'b0;
    end else begin
      en_q <= en_i;
      if (!en_i) begin
        st_q <= ST_IDLE;
      end else begin
        unique case (st_q)
          ST_IDLE: if (!en_q && mode_ok) begin
            cnt_q   <= dir_up_i ? '0 : load_eff_i;
            ticks_q <= '0;
            st_q    <= wait_trig_i ? ST_WAIT : ST_RUN;
          end
          ST_WAIT: if (chain_trig_i) st_q <= ST_RUN;
          ST_RUN: begin
            ticks_q <= ticks_q + 1'b1;
            if (restart) begin
              cnt_q <= imm_val_i;
            end else if (terminal) begin
              if (oneshot) st_q <= ST_DONE;
              else         cnt_q <= dir_up_i ? '0 : load_eff_i;
            end else begin
              cnt_q <= dir_up_i ? cnt_q + 1'b1 : cnt_q - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_events.sv
// Event masking and snapshot capture, all outputs registered
module tmr_events #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tc_i,
  input  logic         hit_i,
  input  logic         periodic_i,
  input  logic         snap_en_i,
  input  logic         to_irq_dis_i,
  input  logic         match_en_i,
  input  logic [W-1:0] ticks_i,
  output logic [W-1:0] snap_o,
  output logic         to_irq_o,
  output logic         to_trig_o,
  output logic         chain_o,
  output logic         match_irq_o,
  output logic         match_trig_o
);
  logic m_evt;
  assign m_evt = hit_i && match_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_o       <= '0;
      to_irq_o     <= 1'b0;
      to_trig_o    <= 1'b0;
      chain_o      <= 1'b0;
      match_irq_o  <= 1'b0;
      match_trig_o <= 1'b0;
    end else begin
      to_trig_o    <= tc_i;
      chain_o      <= tc_i;
      to_irq_o     <= tc_i && !to_irq_dis_i;
      match_irq_o  <= m_evt;
      match_trig_o <= m_evt;
      if (tc_i && periodic_i && snap_en_i) snap_o <= ticks_i;
    end
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic             dir_up_i,
  input  logic             load_defer_i,
  input  logic             match_defer_i,
  input  logic             snap_en_i,
  input  logic             wait_trig_i,
  input  logic             chain_trig_i,
  input  logic             to_irq_dis_i,
  input  logic             match_irq_en_i,
  input  logic             load_we_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             match_we_i,
  input  logic [CNT_W-1:0] match_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] snap_o,
  output logic             to_irq_o,
  output logic             match_irq_o,
  output logic             to_trig_o,
  output logic             match_trig_o,
  output logic             chain_trig_o
);
  logic [CNT_W-1:0] load_act, load_eff, match_act, match_eff, ticks;
  logic             load_imm, match_imm, run, tc, start, apply, hit;

  assign apply = tc || start;
  assign hit   = run && (count_o == match_act);

  // defer select is meaningless when counting up
  tmr_shadow #(.W(CNT_W)) u_load (
    .clk_i, .rst_ni,
    .we_i(load_we_i), .val_i(load_val_i),
    .defer_i(load_defer_i && !dir_up_i), .apply_i(apply),
    .act_o(load_act), .eff_o(load_eff), .imm_o(load_imm)
  );

  tmr_shadow #(.W(CNT_W)) u_match (
    .clk_i, .rst_ni,
    .we_i(match_we_i), .val_i(match_val_i),
    .defer_i(match_defer_i), .apply_i(apply),
    .act_o(match_act), .eff_o(match_eff), .imm_o(match_imm)
  );

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .en_i, .mode_i, .dir_up_i, .wait_trig_i, .chain_trig_i,
    .load_act_i(load_act), .load_eff_i(load_eff),
    .imm_load_i(load_imm), .imm_val_i(load_val_i),
    .cnt_o(count_o), .ticks_o(ticks), .run_o(run), .tc_o(tc), .start_o(start)
  );

  tmr_events #(.W(CNT_W)) u_evt (
    .clk_i, .rst_ni,
    .tc_i(tc), .hit_i(hit), .periodic_i(mode_i == MODE_PER),
    .snap_en_i, .to_irq_dis_i, .match_en_i(match_irq_en_i),
    .ticks_i(ticks), .snap_o,
    .to_irq_o, .to_trig_o, .chain_o(chain_trig_o),
    .match_irq_o, .match_trig_o
  );

  // match shadow outputs not otherwise needed at top level
  logic unused_match;
  assign unused_match = ^{match_eff, match_imm};
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [1:0]       mode_i,
  input logic             match_irq_en_i,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] snap_o,
  input logic             to_irq_o,
  input logic             to_trig_o,
  input logic             match_trig_o
);
  AST_ONESHOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_trig_o && mode_i == 2'd1 && en_i) |=> (!en_i || $stable(count_o))); // R4

  AST_IRQ_NEEDS_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_irq_o |-> to_trig_o); // R10

  AST_MATCH_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_trig_o |-> $past(match_irq_en_i)); // R11

  AST_SNAP_ON_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !to_trig_o |-> $stable(snap_o)); // R9

  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !to_trig_o); // R12
endmodule

bind tmr_core tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode_i),
  .match_irq_en_i(match_irq_en_i), .count_o(count_o), .snap_o(snap_o),
  .to_irq_o(to_irq_o), .to_trig_o(to_trig_o), .match_trig_o(match_trig_o)
);

// File: tb/sim_tmr_core.sv
module sim_tmr_core;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, dir_up = 0, ldef = 0, mdef = 0, snap_en = 0, wtrig = 0, ctrig = 0;
  logic irq_dis = 0, men = 0, lwe = 0, mwe = 0;
  logic [1:0]  mode = 0;
  logic [15:0] lval = 0, mval = 0;
  logic [15:0] count, snap;
  logic to_irq, m_irq, to_trig, m_trig, chain;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string phase = "R12 reset";

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode), .dir_up_i(dir_up),
    .load_defer_i(ldef), .match_defer_i(mdef), .snap_en_i(snap_en),
    .wait_trig_i(wtrig), .chain_trig_i(ctrig), .to_irq_dis_i(irq_dis),
    .match_irq_en_i(men), .load_we_i(lwe), .load_val_i(lval),
    .match_we_i(mwe), .match_val_i(mval), .count_o(count), .snap_o(snap),
    .to_irq_o(to_irq), .match_irq_o(m_irq), .to_trig_o(to_trig),
    .match_trig_o(m_trig), .chain_trig_o(chain)
  );

  // reference model: 0 idle, 1 waiting, 2 running, 3 finished
  int run_state, r_cnt, r_tick, r_load, r_lpend, r_match, r_mpend, r_snap;
  bit r_lhas, r_mhas, r_en_d;
  bit x_toirq, x_totrig, x_mirq, x_chain;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_state = 0; r_cnt = 0; r_tick = 0; r_load = 0; r_lpend = 0;
      r_match = 0; r_mpend = 0; r_snap = 0; r_lhas = 0; r_mhas = 0; r_en_d = 0;
      x_toirq = 0; x_totrig = 0; x_mirq = 0; x_chain = 0;
    end else begin
      bit running, at_end, timeout, rise, ld_now, ld_late, hit;
      int nxt_load, old_load, old_match, n_cnt, n_state, n_tick;
      running  = (run_state == 2) && en;
      ld_now   = lwe && !(ldef && !dir_up);
      ld_late  = lwe && ldef && !dir_up;
      at_end   = dir_up ? (r_cnt == r_load) : (r_cnt == 0);
      timeout  = running && at_end && !(ld_now && !dir_up);
      hit      = running && (r_cnt == r_match);
      rise     = en && !r_en_d;
      old_load = r_load; old_match = r_match;
      nxt_load = r_lhas ? r_lpend : r_load;
      n_cnt = r_cnt; n_state = run_state; n_tick = r_tick;
      if (!en) n_state = 0;
      else if (run_state == 0) begin
        if (rise && (mode == 1 || mode == 2)) begin
          n_cnt = dir_up ? 0 : nxt_load;
          n_tick = 0;
          n_state = wtrig ? 1 : 2;
        end
      end else if (run_state == 1) begin
        if (ctrig) n_state = 2;
      end else if (run_state == 2) begin
        n_tick = (r_tick + 1) % 65536;
        if (ld_now && !dir_up) n_cnt = lval;
        else if (at_end) begin
          if (mode == 1) n_state = 3;
          else n_cnt = dir_up ? 0 : nxt_load;
        end else n_cnt = dir_up ? (r_cnt + 1) % 65536 : (r_cnt + 65535) % 65536;
      end
      // shadow values
      if (ld_now) r_load = lval;
      else if ((timeout || rise) && r_lhas) r_load = r_lpend;
      if (ld_late) begin r_lpend = lval; r_lhas = 1; end
      else if (timeout || rise) r_lhas = 0;
      if (mwe && !mdef) r_match = mval;
      else if ((timeout || rise) && r_mhas) r_match = r_mpend;
      if (mwe && mdef) begin r_mpend = mval; r_mhas = 1; end
      else if (timeout || rise) r_mhas = 0;
      if (timeout && mode == 2 && snap_en) r_snap = r_tick;
      x_totrig = timeout; x_chain = timeout;
      x_toirq = timeout && !irq_dis;
      x_mirq = hit && men;
      r_cnt = n_cnt; run_state = n_state; r_tick = n_tick; r_en_d = en;
      if (old_load < 0 || old_match < 0) $display("model range error");
    end
  end

  task automatic cmp(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] at cycle %0d: actual %0d expected %0d", phase, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      cmp("count R2/R3", count, r_cnt);
      cmp("snap R9", snap, r_snap);
      cmp("to_trig R10", to_trig, x_totrig);
      cmp("chain R10", chain, x_chain);
      cmp("to_irq R10", to_irq, x_toirq);
      cmp("match_irq R11", m_irq, x_mirq);
      cmp("match_trig R11", m_trig, x_mirq);
    end
    if (cyc > WD_LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic wr_load(int v, bit d);
    ldef = d; lval = v[15:0]; lwe = 1; tick(1); lwe = 0;
  endtask
  task automatic wr_match(int v, bit d);
    mdef = d; mval = v[15:0]; mwe = 1; tick(1); mwe = 0;
  endtask
  task automatic restart(logic [1:0] m, bit up);
    en = 0; tick(1); mode = m; dir_up = up; en = 1;
  endtask

  initial begin
    tick(2);
    // R12: reset state
    phase = "R12 reset";
    cmp("count R12", count, 0); cmp("snap R12", snap, 0);
    cmp("events R12", {to_irq, m_irq, to_trig, m_trig, chain}, 0);
    rst_n = 1; tick(1);

    phase = "R2 periodic down"; wr_load(5, 0);
    restart(2'd2, 0); tick(20);
    phase = "R10 irq disabled"; irq_dis = 1; tick(14); irq_dis = 0;
    phase = "R3 periodic up"; snap_en = 1; wr_load(4, 0); restart(2'd2, 1); tick(16);
    phase = "R9 snapshot down"; restart(2'd2, 0); tick(20); snap_en = 0;
    phase = "R4 one-shot down"; wr_load(3, 0); restart(2'd1, 0); tick(12);
    phase = "R4 one-shot up"; restart(2'd1, 1); tick(10);
    phase = "R1 mode 0"; restart(2'd0, 0); tick(10);
    phase = "R1 mode 3"; restart(2'd3, 0); tick(10);
    phase = "R5 deferred load"; wr_load(6, 0); restart(2'd2, 0); tick(3);
    wr_load(2, 1); tick(15);
    phase = "R5 immediate load"; wr_load(4, 0); tick(12);
    phase = "R5 defer ignored up"; restart(2'd2, 1); tick(2); wr_load(7, 1); tick(14);
    phase = "R11 match on"; men = 1; wr_load(8, 0); wr_match(5, 0); restart(2'd2, 0); tick(20);
    phase = "R6 match deferred"; wr_match(2, 1); tick(20);
    phase = "R6 match immediate"; wr_match(6, 0); tick(12);
    phase = "R11 match masked"; men = 0; tick(20); men = 1;
    phase = "R7 pending at enable"; en = 0; tick(2);
    dir_up = 0; wr_load(3, 1); wr_match(1, 1); tick(2); en = 1; tick(14);
    phase = "R8 wait trigger"; wtrig = 1; restart(2'd2, 0); tick(6);
    ctrig = 1; tick(1); ctrig = 0; tick(12); wtrig = 0;
    phase = "R12 disable mid-run"; tick(2); en = 0; tick(8);
    phase = "R8 chain held"; wtrig = 1; en = 1; tick(5); ctrig = 1; tick(1); ctrig = 0;
    tick(8); wtrig = 0; en = 0; tick(3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule